// File: doc/BRIEF.md
# Serial Voltage-Code Write Receiver

This block is the receive side of a two-wire serial voltage-ID bus. A fast system clock oversamples the bus clock and data lines. The block waits for a start condition and shifts in an address byte. If the address belongs to it, the block acknowledges by pulling the data line low. It then takes one data byte, acknowledges it, and hands the result to the regulator logic. The result is a low-power indicator, a 7-bit voltage code and one update strobe per rail.

The bus master owns the clock line and the block never stretches it, so the clock pin is input only. The data pin is open drain: the block exposes only a drive-low enable, and the pad and pull-up sit outside. Serial operation is gated by an enable input. While that input is low, all bus traffic is ignored.

Top module: `vidrx_top`

## Requirements
- R1: After reset, `lowPowerN` is 1, `vidCode` is 0, `railStrobe` is 0 and `busDataOe` is 0.
- R2: A falling edge of the data line while the clock line is high starts a transaction. Bits are sampled on rising edges of the clock line, most significant bit first.
- R3: An address byte is accepted when bits 7:5 equal 3'b110, bit 0 (the write flag) is 0 and bits 2:1 are not 2'b00. Bits 4:3 are ignored. Acceptance is signalled by `busDataOe` being high throughout the high phase of the 9th clock pulse.
- R4: A rejected address byte gets no acknowledge. The rest of that transaction then gives no second acknowledge, no strobe and no change to `vidCode` or `lowPowerN`.
- R5: Address bits 2:1 choose the rails. 2'b10 selects rail 1 only (`railStrobe[0]`), 2'b01 selects rail 2 only (`railStrobe[1]`) and 2'b11 selects both. Each strobe is a single-cycle pulse.
- R6: After an accepted address, the 8 data bits are followed by a second acknowledge, driven the same way as in R3.
- R7: Data bit 7 appears on `lowPowerN`: 0 drives the low-power output low and 1 releases it high. Data bits 6:0 appear on `vidCode`. Both update together with the rail strobe, as soon as the 8th data bit is sampled, and hold until the next accepted data byte.
- R8: A stop condition (data line rising while the clock line is high) aborts the current transaction. A new start condition also aborts it and restarts address reception. An aborted transaction produces no strobe.
- R9: While `serialEn` is 0, the block does not acknowledge, strobe or change its outputs, whatever the bus does.
- R10: `busDataOe` is only turned on after a falling edge of the clock line. Outside the two acknowledge slots it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| serialEn | input | 1 | Enables serial reception |
| busClk | input | 1 | Bus clock line (input only) |
| busDataIn | input | 1 | Sensed level of the bus data line |
| busDataOe | output | 1 | 1 pulls the bus data line low |
| lowPowerN | output | 1 | Low-power indicator, active low |
| vidCode | output | 7 | Requested voltage code |
| railStrobe | output | 2 | Per-rail update pulse, bit 0 for rail 1 and bit 1 for rail 2 |

## Verification
The bench builds the block with its default two-stage synchronizers and address tag 3'b110. Every bus bit lasts 16 system clocks, which leaves the acknowledge timing well clear of the synchronizer delay. This small setup lets the bench sweep all 256 address bytes, covering every don't-care combination, every rail selection and every rejected address. It also sweeps all 128 voltage codes with the low-power bit toggling. Separate transactions cover disabled operation, abort by stop in the middle of the data byte, and a restart in the middle of the address byte.

// File: rtl/vidrx_pkg.sv
package vidrx_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int RAILS  = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_A_SETUP, ST_A_DRIVE, ST_A_HOLD,
    ST_DATA, ST_D_SETUP, ST_D_DRIVE, ST_D_HOLD, ST_SKIP
  } rxState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCount;
    logic shiftEn;
    logic latchAddr;
    logic latchOut;
  } ctrlCmd_t;

  // Bus events and byte status from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startEv;
    logic stopEv;
    logic byteFull;
    logic addrHit;
  } busEvt_t;
endpackage

// File: rtl/vidrx_sync.sv
module vidrx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= RESET_VAL;
          else       chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= RESET_VAL;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/vidrx_datapath.sv
module vidrx_datapath
  import vidrx_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [2:0] ADDR_TAG    = 3'b110
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busClk,
  input  logic              busDataIn,
  input  ctrlCmd_t          cmd,
  output busEvt_t           evt,
  output logic [CODE_W-1:0] vidCode,
  output logic              lowPowerN,
  output logic [RAILS-1:0]  railStrobe
);
  logic sclS, sdaS, sclP, sdaP;
  logic [BYTE_W-1:0] shReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [RAILS-1:0]  railSel;

  vidrx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_syncScl (
    .clk(clk), .rstN(rstN), .din(busClk), .dout(sclS));
  vidrx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_syncSda (
    .clk(clk), .rstN(rstN), .din(busDataIn), .dout(sdaS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
    end
  end

  // Edge events; start/stop need the clock high in both samples
  always_comb begin
    evt.sclRise  = sclS & ~sclP;
    evt.sclFall  = ~sclS & sclP;
    evt.startEv  = sclS & sclP & sdaP & ~sdaS;
    evt.stopEv   = sclS & sclP & ~sdaP & sdaS;
    evt.byteFull = (bitCnt == CNT_W'(BYTE_W));
    evt.addrHit  = (shReg[7:5] == ADDR_TAG) && !shReg[0] && (shReg[2:1] != 2'b00);
  end

  // Shift register and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else if (cmd.clrCount) begin
      bitCnt <= '0;
    end else if (cmd.shiftEn) begin
      shReg  <= {shReg[BYTE_W-2:0], sdaS};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // Rail selection latched from address bits 2:1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              railSel <= '0;
    else if (cmd.latchAddr) railSel <= {shReg[1], shReg[2]};
  end

  // Output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vidCode    <= '0;
      lowPowerN  <= 1'b1;
      railStrobe <= '0;
    end else begin
      railStrobe <= cmd.latchOut ? railSel : '0;
      if (cmd.latchOut) begin
        vidCode   <= shReg[CODE_W-1:0];
        lowPowerN <= shReg[BYTE_W-1];
      end
    end
  end

  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    (|railStrobe) |=> (railStrobe == '0));
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W));
  a_r7_outputs_move_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vidCode) |-> (|railStrobe));
endmodule

// File: rtl/vidrx_ctrl.sv
module vidrx_ctrl
  import vidrx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     serialEn,
  input  busEvt_t  evt,
  output ctrlCmd_t cmd,
  output logic     ackDrive
);
  rxState_t state, nxt;

  always_comb begin
    nxt = state;
    cmd = '0;
    if (!serialEn) begin
      nxt = ST_IDLE;
    end else if (evt.startEv) begin
      nxt = ST_ADDR;
      cmd.clrCount = 1'b1;
    end else if (evt.stopEv) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (evt.byteFull) begin
            cmd.clrCount = 1'b1;
            if (evt.addrHit) begin
              cmd.latchAddr = 1'b1;
              nxt = ST_A_SETUP;
            end else begin
              nxt = ST_SKIP;
            end
          end else if (evt.sclRise) begin
            cmd.shiftEn = 1'b1;
          end
        end
        ST_A_SETUP: if (evt.sclFall) nxt = ST_A_DRIVE;
        ST_A_DRIVE: if (evt.sclRise) nxt = ST_A_HOLD;
        ST_A_HOLD:  if (evt.sclFall) nxt = ST_DATA;
        ST_DATA: begin
          if (evt.byteFull) begin
            cmd.clrCount = 1'b1;
            cmd.latchOut = 1'b1;
            nxt = ST_D_SETUP;
          end else if (evt.sclRise) begin
            cmd.shiftEn = 1'b1;
          end
        end
        ST_D_SETUP: if (evt.sclFall) nxt = ST_D_DRIVE;
        ST_D_DRIVE: if (evt.sclRise) nxt = ST_D_HOLD;
        ST_D_HOLD:  if (evt.sclFall) nxt = ST_SKIP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign ackDrive = (state == ST_A_DRIVE) || (state == ST_A_HOLD) ||
                    (state == ST_D_DRIVE) || (state == ST_D_HOLD);

  a_r9_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !serialEn |=> !ackDrive);
  a_r10_drive_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> $past(evt.sclFall));
  a_r2_shift_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    cmd.shiftEn |-> evt.sclRise);
  a_r7_latch_on_full_byte: assert property (@(posedge clk) disable iff (!rstN)
    cmd.latchOut |-> evt.byteFull);
  a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (serialEn && evt.startEv) |=> (state == ST_ADDR));
endmodule

// File: rtl/vidrx_top.sv
module vidrx_top
  import vidrx_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [2:0] ADDR_TAG    = 3'b110
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialEn,
  input  logic              busClk,
  input  logic              busDataIn,
  output logic              busDataOe,
  output logic              lowPowerN,
  output logic [CODE_W-1:0] vidCode,
  output logic [RAILS-1:0]  railStrobe
);
  ctrlCmd_t cmd;
  busEvt_t  evt;

  vidrx_datapath #(.SYNC_STAGES(SYNC_STAGES), .ADDR_TAG(ADDR_TAG)) u_dp (
    .clk(clk), .rstN(rstN), .busClk(busClk), .busDataIn(busDataIn),
    .cmd(cmd), .evt(evt), .vidCode(vidCode), .lowPowerN(lowPowerN),
    .railStrobe(railStrobe));

  vidrx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .serialEn(serialEn), .evt(evt),
    .cmd(cmd), .ackDrive(busDataOe));
endmodule

// File: tb/vidrx_top_bench.sv
module vidrx_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serialEn = 1'b1;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic busDataIn;
  logic busDataOe, lowPowerN;
  logic [6:0] vidCode;
  logic [1:0] railStrobe;

  int checks = 0;
  int fails = 0;
  logic [1:0] strobeAcc = 2'b00;
  logic clrAcc = 1'b0;
  logic [6:0] expVid = 7'd0;
  logic expLpn = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign busDataIn = mSda & ~busDataOe;

  vidrx_top u_vidrx_top (
    .clk(clk), .rstN(rstN), .serialEn(serialEn), .busClk(mScl),
    .busDataIn(busDataIn), .busDataOe(busDataOe), .lowPowerN(lowPowerN),
    .vidCode(vidCode), .railStrobe(railStrobe));

  always @(negedge clk) begin
    if (clrAcc) strobeAcc <= 2'b00;
    else        strobeAcc <= strobeAcc | railStrobe;
  end

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    mSda = 1'b1; waitC(H);
    mScl = 1'b1; waitC(H);
    mSda = 1'b0; waitC(H);
    mScl = 1'b0; waitC(H);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitC(H);
    mScl = 1'b1; waitC(H);
    mSda = 1'b1; waitC(H);
  endtask

  task automatic sendBit(input logic b);
    mSda = b;    waitC(H);
    mScl = 1'b1; waitC(H);
    mScl = 1'b0;
  endtask

  task automatic ackBit(output logic got);
    mSda = 1'b1; waitC(H);
    mScl = 1'b1; waitC(H/2);
    got = (busDataIn == 1'b0);
    waitC(H/2);
    mScl = 1'b0; waitC(H);
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic xfer(input logic [7:0] a, input logic [7:0] d,
                      output logic ackA, output logic ackD);
    clrAcc = 1'b1; waitC(1); clrAcc = 1'b0;
    busStart();
    sendByte(a);
    ackBit(ackA);
    sendByte(d);
    ackBit(ackD);
    busStop();
    waitC(4);
  endtask

  function automatic logic hitOf(input logic [7:0] a);
    return (a[7:5] == 3'b110) && !a[0] && (a[2:1] != 2'b00);
  endfunction

  // Full transaction with expected values from the requirements
  task automatic runCase(input logic [7:0] a, input logic [7:0] d);
    logic ackA, ackD, hit;
    hit = hitOf(a) && serialEn;
    xfer(a, d, ackA, ackD);
    if (hit) begin
      expVid = d[6:0];
      expLpn = d[7];
    end
    chk("R3/R4/R9 address ack", {31'd0, ackA}, {31'd0, hit});
    chk("R6/R4 data ack", {31'd0, ackD}, {31'd0, hit});
    chk("R5 rail strobes", {30'd0, strobeAcc}, hit ? {30'd0, a[1], a[2]} : 32'd0);
    chk("R7 code and low-power", {24'd0, lowPowerN, vidCode}, {24'd0, expLpn, expVid});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", fails, checks + 1);
    $finish;
  end

  initial begin
    logic ackA, ackD;
    waitC(5);
    // R1 reset state
    chk("R1 reset lowPowerN", {31'd0, lowPowerN}, 32'd1);
    chk("R1 reset vidCode", {25'd0, vidCode}, 32'd0);
    chk("R1 reset oe/strobe", {29'd0, busDataOe, railStrobe}, 32'd0);
    rstN = 1'b1;
    waitC(5);

    // R2 R3 R4 R5: sweep every address byte
    for (int a = 0; a < 256; a++) runCase(8'(a), 8'(a) ^ 8'h5A);

    // R7: sweep every voltage code, low-power bit toggling
    for (int c = 0; c < 128; c++) runCase(8'hC6, {c[0] ^ c[3], 7'(c)});

    // R9: disabled, a valid write is ignored
    serialEn = 1'b0;
    runCase(8'hC4, 8'h13);
    serialEn = 1'b1;
    waitC(4);

    // R8: stop in the middle of the data byte aborts without strobe
    clrAcc = 1'b1; waitC(1); clrAcc = 1'b0;
    busStart();
    sendByte(8'hC6);
    ackBit(ackA);
    chk("R8 ack before abort", {31'd0, ackA}, 32'd1);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    busStop();
    waitC(4);
    chk("R8 stop abort no strobe", {30'd0, strobeAcc}, 32'd0);
    chk("R8 stop abort outputs held", {24'd0, lowPowerN, vidCode}, {24'd0, expLpn, expVid});

    // R8: restart in the middle of the address byte
    clrAcc = 1'b1; waitC(1); clrAcc = 1'b0;
    busStart();
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    busStart();
    sendByte(8'hD2);
    ackBit(ackA);
    sendByte(8'h27);
    ackBit(ackD);
    busStop();
    waitC(4);
    expVid = 7'h27; expLpn = 1'b0;
    chk("R8 restart address ack", {31'd0, ackA}, 32'd1);
    chk("R8 restart data ack", {31'd0, ackD}, 32'd1);
    chk("R8 restart rail 2 strobe", {30'd0, strobeAcc}, 32'd2);
    chk("R8 restart outputs", {24'd0, lowPowerN, vidCode}, {24'd0, expLpn, expVid});
    chk("R10 oe idle after transaction", {31'd0, busDataOe}, 32'd0);

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule